// File: doc/BRIEF.md
# Low-Power Mode Controller

This controller sits in the always-on domain of a small system and moves it between Run and three sleep depths: Sleep, Stop and Standby. A sleep request picks its depth from two select inputs. The controller then drives the gating of the CPU clock and the core clocks. It also drives the enables of the PLL, the internal RC oscillator and the crystal oscillator, the regulator on/low-power controls, the core-domain power switch and the core-domain reset.

Each depth has its own set of wake sources. Sleep returns to Run on any enabled interrupt or event line. Stop returns to Run through a wake line: one of the external lines or one of the internal sources, such as the supply monitor, RTC, USB or Ethernet. Only the RC oscillator is restarted, and a settling delay runs before the clocks are ungated. Standby switches the core domain off. It can only end through a reset-style exit: a reset pin, a watchdog reset, an RTC event or a synchronised edge on the wake pin. That exit restores power first and then holds the core reset for a fixed number of cycles. The RTC and watchdog clock enables never drop.

Top module: `pmc_lpm_ctrl`

## Requirements
- R1: While `rst_ni` is low, the outputs show the power-up state. Core reset is asserted (`core_rst_no`=0), core power and the regulator are on, the RC oscillator is on, and the CPU clock, core clocks, PLL, crystal and low-power regulator mode are all off.
- R2: Once power-good is high and no reset source is active, the CPU and core clocks run with core reset held for exactly `RST_CYC` cycles. The controller then enters Run with core reset released and every clock and oscillator enabled. Core reset is never released unless power-good was high in the cycle before.
- R3: A sleep request with `deep_sel_i`=0 enters Sleep, which gates only the CPU clock. In Sleep, any `irq_i` line returns to Run on the next cycle. Stop wake lines have no effect in Sleep.
- R4: A sleep request with `deep_sel_i`=1 and `stby_sel_i`=0 enters Stop. Stop gates the CPU and core clocks and disables the PLL, the RC oscillator and the crystal, while the regulator stays on. `reg_lp_o` equals `reg_lp_sel_i` as sampled on entry and ignores later changes of that input.
- R5: Stop is left only through a bit of `ext_wake_i` or `int_wake_i`. The `irq_i` lines have no effect in Stop.
- R6: When a Stop wake line is seen, only the RC oscillator is re-enabled, and the clocks stay gated for `stab_cyc_i`+1 cycles. `stab_cyc_i` is sampled in the wake cycle. The controller then enters Run with the CPU and core clocks on, and the PLL and crystal still off until the next core reset.
- R7: A sleep request with both selects at 1 enters Standby. In Standby the regulator and core power are off, core reset is asserted, and every core clock and oscillator is off.
- R8: Standby is left on an RTC event, a wake-pin edge, a watchdog reset or a reset-pin assertion. `irq_i` and the Stop wake lines have no effect. On exit, core power and the regulator return while core reset stays asserted until power-good is high. After that, the R2 sequence follows.
- R9: The wake pin passes through two synchroniser flops and an edge detector. A rising edge ends Standby in the third cycle after it is applied. A pin that is already high on entry never ends Standby.
- R10: `rtc_clk_en_o` and `wdg_clk_en_o` are high in every state, including reset, Stop and Standby.
- R11: A sleep request is ignored, and the controller stays in Run, when a wake source of the requested depth is already pending. Those sources are `irq_i` for Sleep, any Stop wake line for Stop, and the RTC event for Standby.
- R12: A low `rst_pin_ni` or a high `wdg_rst_i` in any state asserts core reset on the next cycle. While the pin stays low, the controller waits with core reset asserted. When it is released, the R2 sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on domain clock |
| rst_ni | input | 1 | Always-on domain reset, active low |
| sleep_req_i | input | 1 | Sleep request pulse from the CPU |
| deep_sel_i | input | 1 | 0: Sleep, 1: Stop or Standby |
| stby_sel_i | input | 1 | With deep select: 0 Stop, 1 Standby |
| reg_lp_sel_i | input | 1 | Regulator low-power choice for Stop |
| stab_cyc_i | input | STAB_W | Oscillator settling count for Stop exit |
| irq_i | input | N_IRQ | Enabled interrupt and event lines |
| ext_wake_i | input | N_EXT | External wake lines |
| int_wake_i | input | N_INT | Internal wake sources (supply monitor, RTC, USB, Ethernet) |
| rtc_evt_i | input | 1 | RTC alarm, wakeup, tamper or timestamp event |
| rst_pin_ni | input | 1 | External reset pin, active low, already synchronous |
| wdg_rst_i | input | 1 | Independent watchdog reset request |
| wkup_pin_i | input | 1 | Asynchronous wake pin |
| pwr_good_i | input | 1 | Core-domain supply good |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| core_clk_en_o | output | 1 | Core-domain peripheral clock enable |
| pll_en_o | output | 1 | PLL enable |
| rc_osc_en_o | output | 1 | Internal RC oscillator enable |
| xtal_en_o | output | 1 | Crystal oscillator enable |
| reg_on_o | output | 1 | Main regulator on |
| reg_lp_o | output | 1 | Regulator in low-power mode |
| core_pwr_en_o | output | 1 | Core-domain power switch enable |
| core_rst_no | output | 1 | Core-domain reset, active low |
| rtc_clk_en_o | output | 1 | RTC clock source enable |
| wdg_clk_en_o | output | 1 | Watchdog clock source enable |

## Verification
Some rules are checked on every cycle. Core power off always implies core reset, regulator off and gated clocks. A stopped RC oscillator implies a stopped PLL, crystal and core clock. Reset pin and watchdog always produce core reset on the next cycle, and the always-on clock enables never fall. Some behaviour only the bench scenarios can show. This covers the exact length of the settling and reset-hold windows, the sampling of the low-power bit and the settling count, the three-cycle latency of the wake pin, and the refusal to sleep with a pending source. The bench sweeps every interrupt line and every Stop wake source through entry and exit.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

   typedef enum logic [2:0] {
      PM_RUN       = 3'd0,
      PM_SLEEP     = 3'd1,
      PM_STOP      = 3'd2,
      PM_STOP_WAKE = 3'd3,
      PM_STBY      = 3'd4,
      PM_PWRUP     = 3'd5,
      PM_RST_HOLD  = 3'd6
   } pm_state_e;

   typedef struct packed {
      logic cpu_clk;
      logic core_clk;
      logic pll;
      logic rc;
      logic xtal;
      logic reg_on;
      logic reg_lp;
      logic pwr;
      logic rst_n;
   } pm_ctl_t;

   function automatic pm_ctl_t pm_decode(input pm_state_e s, input logic lp, input logic osc);
      pm_ctl_t c;
      c = '0;
      case (s)
         PM_RUN: begin
            c.cpu_clk = 1'b1; c.core_clk = 1'b1; c.pll = osc; c.rc = 1'b1; c.xtal = osc;
            c.reg_on = 1'b1; c.pwr = 1'b1; c.rst_n = 1'b1;
         end
         PM_SLEEP: begin
            c.core_clk = 1'b1; c.pll = osc; c.rc = 1'b1; c.xtal = osc;
            c.reg_on = 1'b1; c.pwr = 1'b1; c.rst_n = 1'b1;
         end
         PM_STOP: begin
            c.reg_on = 1'b1; c.reg_lp = lp; c.pwr = 1'b1; c.rst_n = 1'b1;
         end
         PM_STOP_WAKE: begin
            c.rc = 1'b1; c.reg_on = 1'b1; c.pwr = 1'b1; c.rst_n = 1'b1;
         end
         PM_STBY: begin
            c = '0;
         end
         PM_RST_HOLD: begin
            c.cpu_clk = 1'b1; c.core_clk = 1'b1; c.rc = 1'b1; c.reg_on = 1'b1; c.pwr = 1'b1;
         end
         default: begin
            c.rc = 1'b1; c.reg_on = 1'b1; c.pwr = 1'b1;
         end
      endcase
      return c;
   endfunction

endpackage

// File: rtl/pmc_wake_sync.sv
module pmc_wake_sync #(
   parameter int STAGES = 2,
   parameter bit RISE   = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pin_i,
   output logic edge_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pmc_wake_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin_i};
         prev_q <= sync_q[STAGES-1];
      end
   end

   if (RISE) begin : g_rise
      assign edge_o = sync_q[STAGES-1] & ~prev_q;
   end else begin : g_fall
      assign edge_o = ~sync_q[STAGES-1] & prev_q;
   end

endmodule

// File: rtl/pmc_wake_agg.sv
module pmc_wake_agg #(
   parameter int N_IRQ = 8,
   parameter int N_EXT = 16,
   parameter int N_INT = 7
) (
   input  logic [N_IRQ-1:0] irq_i,
   input  logic [N_EXT-1:0] ext_wake_i,
   input  logic [N_INT-1:0] int_wake_i,
   input  logic             rtc_evt_i,
   input  logic             pin_edge_i,
   input  logic             rst_pin_ni,
   input  logic             wdg_rst_i,
   output logic             wk_sleep_o,
   output logic             wk_stop_o,
   output logic             wk_stby_o,
   output logic             hard_rst_o
);

   if (N_IRQ < 1 || N_EXT < 1 || N_INT < 1) begin : g_bad_width
      $error("pmc_wake_agg: every wake group needs at least one line");
   end

   assign wk_sleep_o = |irq_i;
   assign wk_stop_o  = (|ext_wake_i) | (|int_wake_i);
   assign wk_stby_o  = rtc_evt_i | pin_edge_i;
   assign hard_rst_o = ~rst_pin_ni | wdg_rst_i;

endmodule

// File: rtl/pmc_dncnt.sv
module pmc_dncnt #(
   parameter int W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         dec_i,
   output logic         zero_o
);

   if (W < 1) begin : g_bad_w
      $error("pmc_dncnt: W must be positive");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (dec_i && cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pmc_lpm_ctrl.sv
module pmc_lpm_ctrl
   import pmc_pkg::*;
#(
   parameter int N_IRQ       = 8,
   parameter int N_EXT       = 16,
   parameter int N_INT       = 7,
   parameter int STAB_W      = 8,
   parameter int RST_CYC     = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit WKUP_RISE   = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sleep_req_i,
   input  logic              deep_sel_i,
   input  logic              stby_sel_i,
   input  logic              reg_lp_sel_i,
   input  logic [STAB_W-1:0] stab_cyc_i,
   input  logic [N_IRQ-1:0]  irq_i,
   input  logic [N_EXT-1:0]  ext_wake_i,
   input  logic [N_INT-1:0]  int_wake_i,
   input  logic              rtc_evt_i,
   input  logic              rst_pin_ni,
   input  logic              wdg_rst_i,
   input  logic              wkup_pin_i,
   input  logic              pwr_good_i,
   output logic              cpu_clk_en_o,
   output logic              core_clk_en_o,
   output logic              pll_en_o,
   output logic              rc_osc_en_o,
   output logic              xtal_en_o,
   output logic              reg_on_o,
   output logic              reg_lp_o,
   output logic              core_pwr_en_o,
   output logic              core_rst_no,
   output logic              rtc_clk_en_o,
   output logic              wdg_clk_en_o
);

   localparam int RC_W  = $clog2(RST_CYC + 1);
   localparam int CNT_W = (STAB_W > RC_W) ? STAB_W : RC_W;

   if (RST_CYC < 1) begin : g_bad_rst
      $error("pmc_lpm_ctrl: RST_CYC must be at least 1");
   end
   if (STAB_W < 1) begin : g_bad_stab
      $error("pmc_lpm_ctrl: STAB_W must be positive");
   end

   pm_state_e        st_q, st_d;
   logic             lp_q, osc_q;
   logic             cnt_ld, cnt_dec, cnt_zero;
   logic [CNT_W-1:0] cnt_val;
   logic             pin_edge;
   logic             wk_sleep, wk_stop, wk_stby, hard_rst;
   pm_ctl_t          ctl;

   pmc_wake_sync #(
      .STAGES (SYNC_STAGES),
      .RISE   (WKUP_RISE)
   ) u_wsync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (wkup_pin_i),
      .edge_o (pin_edge)
   );

   pmc_wake_agg #(
      .N_IRQ (N_IRQ),
      .N_EXT (N_EXT),
      .N_INT (N_INT)
   ) u_wagg (
      .irq_i      (irq_i),
      .ext_wake_i (ext_wake_i),
      .int_wake_i (int_wake_i),
      .rtc_evt_i  (rtc_evt_i),
      .pin_edge_i (pin_edge),
      .rst_pin_ni (rst_pin_ni),
      .wdg_rst_i  (wdg_rst_i),
      .wk_sleep_o (wk_sleep),
      .wk_stop_o  (wk_stop),
      .wk_stby_o  (wk_stby),
      .hard_rst_o (hard_rst)
   );

   pmc_dncnt #(
      .W (CNT_W)
   ) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (cnt_ld),
      .load_val_i (cnt_val),
      .dec_i      (cnt_dec),
      .zero_o     (cnt_zero)
   );

   always_comb begin
      st_d    = st_q;
      cnt_ld  = 1'b0;
      cnt_dec = 1'b0;
      cnt_val = '0;
      if (hard_rst) begin
         st_d = PM_PWRUP;
      end else begin
         case (st_q)
            PM_RUN: begin
               if (sleep_req_i) begin
                  if (!deep_sel_i) begin
                     if (!wk_sleep) st_d = PM_SLEEP;
                  end else if (!stby_sel_i) begin
                     if (!wk_stop) st_d = PM_STOP;
                  end else if (!wk_stby) begin
                     st_d = PM_STBY;
                  end
               end
            end
            PM_SLEEP: begin
               if (wk_sleep) st_d = PM_RUN;
            end
            PM_STOP: begin
               if (wk_stop) begin
                  st_d    = PM_STOP_WAKE;
                  cnt_ld  = 1'b1;
                  cnt_val = CNT_W'(stab_cyc_i);
               end
            end
            PM_STOP_WAKE: begin
               if (cnt_zero) st_d = PM_RUN;
               else          cnt_dec = 1'b1;
            end
            PM_STBY: begin
               if (wk_stby) st_d = PM_PWRUP;
            end
            PM_PWRUP: begin
               if (pwr_good_i) begin
                  st_d    = PM_RST_HOLD;
                  cnt_ld  = 1'b1;
                  cnt_val = CNT_W'(RST_CYC - 1);
               end
            end
            PM_RST_HOLD: begin
               if (!pwr_good_i)   st_d = PM_PWRUP;
               else if (cnt_zero) st_d = PM_RUN;
               else               cnt_dec = 1'b1;
            end
            default: st_d = PM_PWRUP;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q  <= PM_PWRUP;
         lp_q  <= 1'b0;
         osc_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_q == PM_RUN && st_d == PM_STOP) begin
            lp_q <= reg_lp_sel_i;
         end
         if (st_d == PM_STOP || st_d == PM_STBY) begin
            osc_q <= 1'b0;
         end else if (st_q == PM_RST_HOLD && st_d == PM_RUN) begin
            osc_q <= 1'b1;
         end
      end
   end

   assign ctl           = pm_decode(st_q, lp_q, osc_q);
   assign cpu_clk_en_o  = ctl.cpu_clk;
   assign core_clk_en_o = ctl.core_clk;
   assign pll_en_o      = ctl.pll;
   assign rc_osc_en_o   = ctl.rc;
   assign xtal_en_o     = ctl.xtal;
   assign reg_on_o      = ctl.reg_on;
   assign reg_lp_o      = ctl.reg_lp;
   assign core_pwr_en_o = ctl.pwr;
   assign core_rst_no   = ctl.rst_n;
   assign rtc_clk_en_o  = 1'b1;
   assign wdg_clk_en_o  = 1'b1;

endmodule

// File: rtl/pmc_lpm_chk.sv
module pmc_lpm_chk #(
   parameter int N_IRQ = 8
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [N_IRQ-1:0] irq_i,
   input logic             rst_pin_ni,
   input logic             wdg_rst_i,
   input logic             pwr_good_i,
   input logic             cpu_clk_en_o,
   input logic             core_clk_en_o,
   input logic             pll_en_o,
   input logic             rc_osc_en_o,
   input logic             xtal_en_o,
   input logic             reg_on_o,
   input logic             reg_lp_o,
   input logic             core_pwr_en_o,
   input logic             core_rst_no,
   input logic             rtc_clk_en_o,
   input logic             wdg_clk_en_o
);

   AST_RELEASE_PG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(core_rst_no) |-> $past(pwr_good_i)); // R2

   AST_SLEEP_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rst_pin_ni && !wdg_rst_i && !cpu_clk_en_o && core_clk_en_o && (|irq_i)) |=> cpu_clk_en_o); // R3

   AST_OSC_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rc_osc_en_o |-> (!pll_en_o && !xtal_en_o && !core_clk_en_o)); // R4

   AST_LP_IN_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reg_lp_o |-> (reg_on_o && !core_clk_en_o && !rc_osc_en_o)); // R4

   AST_DOMAIN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !core_pwr_en_o |-> (!reg_on_o && !core_rst_no && !cpu_clk_en_o && !core_clk_en_o)); // R7

   AST_PWR_BEFORE_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(core_pwr_en_o) |-> !core_rst_no); // R8

   AST_AON_CLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rtc_clk_en_o && wdg_clk_en_o); // R10

   AST_PIN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rst_pin_ni |=> !core_rst_no); // R12

   AST_WDG_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wdg_rst_i |=> !core_rst_no); // R12

endmodule

bind pmc_lpm_ctrl pmc_lpm_chk #(.N_IRQ(N_IRQ)) u_lpm_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .irq_i         (irq_i),
   .rst_pin_ni    (rst_pin_ni),
   .wdg_rst_i     (wdg_rst_i),
   .pwr_good_i    (pwr_good_i),
   .cpu_clk_en_o  (cpu_clk_en_o),
   .core_clk_en_o (core_clk_en_o),
   .pll_en_o      (pll_en_o),
   .rc_osc_en_o   (rc_osc_en_o),
   .xtal_en_o     (xtal_en_o),
   .reg_on_o      (reg_on_o),
   .reg_lp_o      (reg_lp_o),
   .core_pwr_en_o (core_pwr_en_o),
   .core_rst_no   (core_rst_no),
   .rtc_clk_en_o  (rtc_clk_en_o),
   .wdg_clk_en_o  (wdg_clk_en_o)
);

// File: tb/tb_pmc_lpm_ctrl.sv
module tb_pmc_lpm_ctrl;

   localparam int N_IRQ   = 8;
   localparam int N_EXT   = 16;
   localparam int N_INT   = 7;
   localparam int STAB_W  = 8;
   localparam int RST_CYC = 4;

   localparam int M_RUN  = 0;
   localparam int M_SLP  = 1;
   localparam int M_STOP = 2;
   localparam int M_SWK  = 3;
   localparam int M_STBY = 4;
   localparam int M_PWUP = 5;
   localparam int M_HOLD = 6;

   logic              clk = 1'b0;
   logic              rst_ni = 1'b0;
   logic              sleep_req = 1'b0, deep_sel = 1'b0, stby_sel = 1'b0, lp_sel = 1'b0;
   logic [STAB_W-1:0] stab = '0;
   logic [N_IRQ-1:0]  irq = '0;
   logic [N_EXT-1:0]  ext_wake = '0;
   logic [N_INT-1:0]  int_wake = '0;
   logic              rtc_evt = 1'b0, rst_pin_n = 1'b1, wdg_rst = 1'b0, wkup = 1'b0, pwr_good = 1'b1;
   logic cpu_en, core_en, pll_en, rc_en, xtal_en, reg_on, reg_lp, pwr_en, core_rst_n, rtc_en, wdg_en;
   logic [10:0] got;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pmc_lpm_ctrl #(
      .N_IRQ(N_IRQ), .N_EXT(N_EXT), .N_INT(N_INT), .STAB_W(STAB_W), .RST_CYC(RST_CYC)
   ) dut (
      .clk_i(clk), .rst_ni(rst_ni), .sleep_req_i(sleep_req), .deep_sel_i(deep_sel),
      .stby_sel_i(stby_sel), .reg_lp_sel_i(lp_sel), .stab_cyc_i(stab), .irq_i(irq),
      .ext_wake_i(ext_wake), .int_wake_i(int_wake), .rtc_evt_i(rtc_evt), .rst_pin_ni(rst_pin_n),
      .wdg_rst_i(wdg_rst), .wkup_pin_i(wkup), .pwr_good_i(pwr_good),
      .cpu_clk_en_o(cpu_en), .core_clk_en_o(core_en), .pll_en_o(pll_en), .rc_osc_en_o(rc_en),
      .xtal_en_o(xtal_en), .reg_on_o(reg_on), .reg_lp_o(reg_lp), .core_pwr_en_o(pwr_en),
      .core_rst_no(core_rst_n), .rtc_clk_en_o(rtc_en), .wdg_clk_en_o(wdg_en)
   );

   // bit order: cpu, core, pll, rc, xtal, reg_on, reg_lp, pwr, rst_n, rtc, wdg
   assign got = {cpu_en, core_en, pll_en, rc_en, xtal_en, reg_on, reg_lp, pwr_en, core_rst_n, rtc_en, wdg_en};

   function automatic logic [10:0] ev(input int m, input logic lp, input logic osc);
      case (m)
         M_RUN:   return {1'b1, 1'b1, osc,  1'b1, osc,  1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
         M_SLP:   return {1'b0, 1'b1, osc,  1'b1, osc,  1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
         M_STOP:  return {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, lp,   1'b1, 1'b1, 1'b1, 1'b1};
         M_SWK:   return {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
         M_STBY:  return {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
         M_PWUP:  return {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
         default: return {1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
      endcase
   endfunction

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [10:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%b exp=%b at %0t", req, got, exp, $time);
      end
   endtask

   task automatic enter(input logic d, input logic s, input logic lp);
      sleep_req = 1'b1; deep_sel = d; stby_sel = s; lp_sel = lp;
      step(1);
      sleep_req = 1'b0;
   endtask

   // from a PWRUP cycle with power good and no reset source
   task automatic powerup(input string req);
      for (int k = 0; k < RST_CYC; k++) begin
         step(1);
         chk(req, ev(M_HOLD, 1'b0, 1'b0));
      end
      step(1);
      chk(req, ev(M_RUN, 1'b0, 1'b1));
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      step(3);
      chk("R1 reset state", ev(M_PWUP, 1'b0, 1'b0));
      rst_ni = 1'b1;
      powerup("R2 power-up hold");

      // R3 sweep of every interrupt line
      for (int i = 0; i < N_IRQ; i++) begin
         enter(1'b0, 1'b0, 1'b0);
         chk("R3 sleep entry", ev(M_SLP, 1'b0, 1'b1));
         ext_wake[i] = 1'b1;
         step(1);
         chk("R3 stop line ignored in sleep", ev(M_SLP, 1'b0, 1'b1));
         ext_wake = '0;
         irq[i] = 1'b1;
         step(1);
         chk("R3 irq wake", ev(M_RUN, 1'b0, 1'b1));
         irq = '0;
      end

      // R11 pending wake blocks entry
      irq[3] = 1'b1;
      enter(1'b0, 1'b0, 1'b0);
      chk("R11 irq pending", ev(M_RUN, 1'b0, 1'b1));
      irq = '0;
      int_wake[1] = 1'b1;
      enter(1'b1, 1'b0, 1'b0);
      chk("R11 stop source pending", ev(M_RUN, 1'b0, 1'b1));
      int_wake = '0;
      ext_wake[9] = 1'b1;
      enter(1'b1, 1'b0, 1'b0);
      chk("R11 ext line pending", ev(M_RUN, 1'b0, 1'b1));
      ext_wake = '0;
      rtc_evt = 1'b1;
      enter(1'b1, 1'b1, 1'b0);
      chk("R11 rtc pending", ev(M_RUN, 1'b0, 1'b1));
      rtc_evt = 1'b0;

      // R4 R5 R6 sweep of every stop wake source and several settling counts
      for (int w = 0; w < N_EXT + N_INT; w++) begin
         logic lp;
         int   s;
         lp = w[0];
         s  = w % 6;
         enter(1'b1, 1'b0, lp);
         chk("R4 stop entry", ev(M_STOP, lp, 1'b0));
         lp_sel = ~lp;
         step(1);
         chk("R4 lp sampled on entry", ev(M_STOP, lp, 1'b0));
         irq = '1;
         step(1);
         chk("R5 irq ignored in stop", ev(M_STOP, lp, 1'b0));
         irq = '0;
         if (w < N_EXT) ext_wake[w] = 1'b1;
         else           int_wake[w - N_EXT] = 1'b1;
         stab = STAB_W'(s);
         step(1);
         chk("R5 R6 wake to settle", ev(M_SWK, 1'b0, 1'b0));
         ext_wake = '0;
         int_wake = '0;
         stab = 8'd20;
         for (int k = 0; k < s; k++) begin
            step(1);
            chk("R6 settling window", ev(M_SWK, 1'b0, 1'b0));
         end
         step(1);
         chk("R6 run without pll and crystal", ev(M_RUN, 1'b0, 1'b0));
      end

      // R3 sleep keeps oscillators as they were
      enter(1'b0, 1'b0, 1'b0);
      chk("R3 sleep after stop", ev(M_SLP, 1'b0, 1'b0));
      irq[7] = 1'b1;
      step(1);
      chk("R3 irq wake after stop", ev(M_RUN, 1'b0, 1'b0));
      irq = '0;

      // R7 R8 R12 standby exits through each source
      for (int src = 0; src < 4; src++) begin
         enter(1'b1, 1'b1, 1'b0);
         chk("R7 R10 standby entry", ev(M_STBY, 1'b0, 1'b0));
         ext_wake = '1; int_wake = '1; irq = '1;
         step(1);
         chk("R8 other wakes ignored in standby", ev(M_STBY, 1'b0, 1'b0));
         ext_wake = '0; int_wake = '0; irq = '0;
         case (src)
            0: begin
               rst_pin_n = 1'b0;
               step(1);
               chk("R12 pin exit", ev(M_PWUP, 1'b0, 1'b0));
               step(2);
               chk("R12 pin held", ev(M_PWUP, 1'b0, 1'b0));
               rst_pin_n = 1'b1;
            end
            1: begin
               wdg_rst = 1'b1;
               step(1);
               chk("R8 watchdog exit", ev(M_PWUP, 1'b0, 1'b0));
               wdg_rst = 1'b0;
            end
            2: begin
               rtc_evt = 1'b1;
               step(1);
               chk("R8 rtc exit", ev(M_PWUP, 1'b0, 1'b0));
               rtc_evt = 1'b0;
            end
            default: begin
               wkup = 1'b1;
               step(1);
               chk("R9 sync stage one", ev(M_STBY, 1'b0, 1'b0));
               step(1);
               chk("R9 sync stage two", ev(M_STBY, 1'b0, 1'b0));
               step(1);
               chk("R9 pin edge exit", ev(M_PWUP, 1'b0, 1'b0));
            end
         endcase
         powerup("R8 reset-style exit");
         wkup = 1'b0;
         step(3);
      end

      // R9 pin already high on entry
      wkup = 1'b1;
      step(4);
      enter(1'b1, 1'b1, 1'b0);
      step(5);
      chk("R9 high level no exit", ev(M_STBY, 1'b0, 1'b0));
      rtc_evt = 1'b1;
      step(1);
      chk("R8 rtc exit", ev(M_PWUP, 1'b0, 1'b0));
      rtc_evt = 1'b0;
      powerup("R8 after level test");
      wkup = 1'b0;
      step(3);

      // R8 power good gates the reset release
      enter(1'b1, 1'b1, 1'b0);
      pwr_good = 1'b0;
      rtc_evt = 1'b1;
      step(1);
      rtc_evt = 1'b0;
      chk("R8 power first", ev(M_PWUP, 1'b0, 1'b0));
      step(3);
      chk("R8 wait for power good", ev(M_PWUP, 1'b0, 1'b0));
      pwr_good = 1'b1;
      powerup("R8 R2 release after power good");

      // R12 reset pin from Run, watchdog from Sleep
      rst_pin_n = 1'b0;
      step(1);
      chk("R12 pin in run", ev(M_PWUP, 1'b0, 1'b0));
      rst_pin_n = 1'b1;
      powerup("R12 pin recovery");
      enter(1'b0, 1'b0, 1'b0);
      wdg_rst = 1'b1;
      step(1);
      chk("R12 watchdog in sleep", ev(M_PWUP, 1'b0, 1'b0));
      wdg_rst = 1'b0;
      powerup("R12 watchdog recovery");

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule